// File: doc/BRIEF.md
# Boolean Condition Register Unit

This block holds sixteen one-bit condition flags, stored as one packed word, for a small processor datapath, together with the logic that reads and rewrites them. One instruction is presented per cycle as an operation code, three 4-bit field indices (`fld_r`, `fld_s`, `fld_t`) and a valid strobe. The unit has four kinds of work:
- two-operand bit logic between flags;
- ANY/ALL reductions over aligned groups of four or eight flags, each giving a single bit that is written back to one flag;
- a flag test that enables a conditional register move;
- a flag test that decides a conditional branch and forms its target address.

A separate special-register port loads the whole flag word at once. That write wins over any same-cycle update.

All flag updates happen on the rising clock edge. The move-enable, branch-taken, branch-target and illegal outputs are combinational and always use the flag values from before the edge. The general register file, instruction fetch and hazard handling sit outside the block.

Top module: `cond_reg_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen flags. Bits 31..16 of `cond_q` always read zero.
- R2: When `sr_wr_en` is high at an edge, the flags take `sr_wr_data[15:0]` and the upper data bits are dropped. This write takes priority over any logic or reduction update in the same cycle.
- R3: For op codes 0 AND, 1 AND-with-complement (b[s] & ~b[t]), 2 OR, 3 OR-with-complement (b[s] | ~b[t]) and 4 XOR, the result of b[s] op b[t] goes into b[r]. No other flag changes.
- R4: Op code 8 is a reduction. In it, `fld_r[1]` picks the group width (1 selects eight flags, 0 selects four) and `fld_r[0]` picks ALL (1) or ANY (0). The group covers flags s upward. The result goes into b[t] and no other flag changes.
- R5: A reduction whose start index is not a multiple of the group width raises `illegal` in that cycle and leaves the flags unchanged.
- R6: `move_en` is high for op 12 (move when b[t] is 0) and for op 13 (move when b[t] is 1) whenever the tested condition holds.
- R7: For op 14, `fld_r` = 0 makes the branch taken when b[s] is 0, and `fld_r` = 1 makes it taken when b[s] is 1. Any other `fld_r` value raises `illegal` and the branch is not taken.
- R8: `branch_target` equals `pc` + 4 + the sign-extended 8-bit `br_offset`.
- R9: With `op_valid` low, the flags change only through the special-register port. In that case `move_en`, `branch_taken` and `illegal` are low.
- R10: The combinational outputs use the flag values before the edge, even when a special-register write lands at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Decoded operation code |
| fld_r | input | 4 | r field index |
| fld_s | input | 4 | s field index |
| fld_t | input | 4 | t field index |
| sr_wr_en | input | 1 | Special-register write enable |
| sr_wr_data | input | 32 | Special-register write data |
| br_offset | input | 8 | Signed branch offset |
| pc | input | 32 | Current instruction address |
| cond_q | output | 32 | Flag word, upper half zero |
| move_en | output | 1 | Conditional move enable |
| branch_taken | output | 1 | Branch decision |
| branch_target | output | 32 | Branch target address |
| illegal | output | 1 | Misaligned reduction or bad branch selector |

## Verification
The hardest case to reach is a cycle in which a special-register write coincides with a flag-updating operation or a flag test. In that cycle the write must win the update, while the test outputs still show the old flags. The directed stimulus first loads a known pattern. It then issues a logic operation and a conditional move together with a write that changes the tested flag, and checks the outputs before the edge and the flags after it. A reduction case loads patterns that separate ANY from ALL within one group and between the two group widths.

// File: rtl/cru_pkg.sv
package cru_pkg;
    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_ANDC   = 4'd1,
        OP_OR     = 4'd2,
        OP_ORC    = 4'd3,
        OP_XOR    = 4'd4,
        OP_REDUCE = 4'd8,
        OP_MOVF   = 4'd12,
        OP_MOVT   = 4'd13,
        OP_BRANCH = 4'd14
    } cru_op_e;
endpackage

// File: rtl/cru_bitop.sv
module cru_bitop
    import cru_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic       a,
    input  logic       b,
    output logic       y,
    output logic       is_logic
);
    always_comb begin
        is_logic = 1'b1;
        y        = 1'b0;
        case (op_code)
            OP_AND:  y = a & b;
            OP_ANDC: y = a & ~b;
            OP_OR:   y = a | b;
            OP_ORC:  y = a | ~b;
            OP_XOR:  y = a ^ b;
            default: is_logic = 1'b0;
        endcase
    end
endmodule

// File: rtl/cru_reduce.sv
module cru_reduce #(
    parameter int NBITS     = 16,
    parameter int IDX_W     = $clog2(NBITS),
    parameter int GRP_SMALL = 4,
    parameter int GRP_LARGE = 8
) (
    input  logic [NBITS-1:0] bits,
    input  logic [IDX_W-1:0] start,
    input  logic             wide,
    input  logic             all_mode,
    output logic             result,
    output logic             misaligned
);
    int  size;
    logic any_v, all_v;

    always_comb begin
        size  = wide ? GRP_LARGE : GRP_SMALL;
        any_v = 1'b0;
        all_v = 1'b1;
        for (int i = 0; i < NBITS; i++) begin
            if (i >= int'(start) && i < int'(start) + size) begin
                any_v = any_v | bits[i];
                all_v = all_v & bits[i];
            end
        end
        misaligned = ((int'(start) % size) != 0);
        result     = all_mode ? all_v : any_v;
    end
endmodule

// File: rtl/cru_cond.sv
module cru_cond
    import cru_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 8
) (
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [IDX_W-1:0]  sel_r,
    input  logic              test_s,
    input  logic              test_t,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  br_offset,
    output logic              move_en,
    output logic              branch_taken,
    output logic [ADDR_W-1:0] branch_target,
    output logic              br_bad
);
    logic is_branch;
    logic [ADDR_W-1:0] off_ext;

    assign is_branch = (op_code == OP_BRANCH);
    assign br_bad    = is_branch && (sel_r > IDX_W'(1));
    assign move_en   = op_valid &&
                       (((op_code == OP_MOVF) && !test_t) ||
                        ((op_code == OP_MOVT) &&  test_t));
    assign branch_taken = op_valid && is_branch && !br_bad &&
                          (sel_r[0] ? test_s : !test_s);
    assign off_ext       = {{(ADDR_W-OFF_W){br_offset[OFF_W-1]}}, br_offset};
    assign branch_target = pc + ADDR_W'(4) + off_ext;
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
    import cru_pkg::*;
#(
    parameter int NBITS     = 16,
    parameter int IDX_W     = $clog2(NBITS),
    parameter int SR_W      = 32,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 8,
    parameter int GRP_SMALL = 4,
    parameter int GRP_LARGE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [IDX_W-1:0]  fld_r,
    input  logic [IDX_W-1:0]  fld_s,
    input  logic [IDX_W-1:0]  fld_t,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [ADDR_W-1:0] pc,
    output logic [SR_W-1:0]   cond_q,
    output logic              move_en,
    output logic              branch_taken,
    output logic [ADDR_W-1:0] branch_target,
    output logic              illegal
);
    localparam int PAD_W = SR_W - NBITS;

    logic [NBITS-1:0] bits_q, bits_d;
    logic             bit_s, bit_t;
    logic             logic_y, logic_sel;
    logic             red_y, red_bad;
    logic             br_bad;
    logic             wr_en, wr_val;
    logic [IDX_W-1:0] wr_idx;
    logic [PAD_W-1:0] sr_unused_hi;

    assign sr_unused_hi = sr_wr_data[SR_W-1:NBITS];
    assign bit_s = bits_q[fld_s];
    assign bit_t = bits_q[fld_t];

    cru_bitop u_bitop (
        .op_code  (op_code),
        .a        (bit_s),
        .b        (bit_t),
        .y        (logic_y),
        .is_logic (logic_sel)
    );

    cru_reduce #(
        .NBITS(NBITS), .IDX_W(IDX_W),
        .GRP_SMALL(GRP_SMALL), .GRP_LARGE(GRP_LARGE)
    ) u_reduce (
        .bits       (bits_q),
        .start      (fld_s),
        .wide       (fld_r[1]),
        .all_mode   (fld_r[0]),
        .result     (red_y),
        .misaligned (red_bad)
    );

    cru_cond #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
    ) u_cond (
        .op_valid      (op_valid),
        .op_code       (op_code),
        .sel_r         (fld_r),
        .test_s        (bit_s),
        .test_t        (bit_t),
        .pc            (pc),
        .br_offset     (br_offset),
        .move_en       (move_en),
        .branch_taken  (branch_taken),
        .branch_target (branch_target),
        .br_bad        (br_bad)
    );

    // Select the single flag written by this operation
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = fld_r;
        wr_val = logic_y;
        if (op_valid) begin
            if (logic_sel) begin
                wr_en = 1'b1;
            end else if (op_code == OP_REDUCE && !red_bad) begin
                wr_en  = 1'b1;
                wr_idx = fld_t;
                wr_val = red_y;
            end
        end
    end

    generate
        for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
            assign bits_d[gi] = (wr_en && wr_idx == IDX_W'(gi)) ? wr_val : bits_q[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (sr_wr_en) begin
            bits_q <= sr_wr_data[NBITS-1:0];
        end else begin
            bits_q <= bits_d;
        end
    end

    assign cond_q  = {{PAD_W{1'b0}}, bits_q};
    assign illegal = op_valid && (((op_code == OP_REDUCE) && red_bad) || br_bad);
endmodule

// File: rtl/cond_reg_unit_chk.sv
module cond_reg_unit_chk
    import cru_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic [3:0]  fld_r,
    input logic [3:0]  fld_s,
    input logic [3:0]  fld_t,
    input logic        sr_wr_en,
    input logic [31:0] sr_wr_data,
    input logic [7:0]  br_offset,
    input logic [31:0] pc,
    input logic [31:0] cond_q,
    input logic        move_en,
    input logic        branch_taken,
    input logic [31:0] branch_target,
    input logic        illegal
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        cond_q[31:16] == 16'h0);

    assert_sr_write_R2: assert property (@(posedge clk) disable iff (rst)
        sr_wr_en |=> cond_q[15:0] == $past(sr_wr_data[15:0]));

    assert_single_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sr_wr_en && op_code <= 4'd4)
        |=> $countones(cond_q ^ $past(cond_q)) <= 1);

    assert_single_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sr_wr_en && op_code == 4'd8)
        |=> $countones(cond_q ^ $past(cond_q)) <= 1);

    assert_illegal_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && illegal && !sr_wr_en) |=> $stable(cond_q));

    assert_move_gated_R6: assert property (@(posedge clk) disable iff (rst)
        move_en |-> (op_valid && (op_code == 4'd12 || op_code == 4'd13)));

    assert_branch_legal_R7: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> (!illegal && fld_r <= 4'd1));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !sr_wr_en) |=> $stable(cond_q));
endmodule

bind cond_reg_unit cond_reg_unit_chk u_chk (.*);

// File: tb/cond_reg_unit_bench.sv
module cond_reg_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code, fld_r, fld_s, fld_t;
    logic        sr_wr_en;
    logic [31:0] sr_wr_data;
    logic [7:0]  br_offset;
    logic [31:0] pc;
    logic [31:0] cond_q;
    logic        move_en, branch_taken, illegal;
    logic [31:0] branch_target;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_reg_unit u_cond_reg_unit (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_model(
        input logic [15:0] cur, input logic v, input logic [3:0] op,
        input logic [3:0] r, input logic [3:0] s, input logic [3:0] t,
        input logic sre, input logic [31:0] srd);
        logic [15:0] nv;
        int sz;
        logic a, b, any_v, all_v;
        nv = cur;
        if (sre) return srd[15:0];
        if (!v) return cur;
        a = cur[s];
        b = cur[t];
        case (op)
            4'd0: nv[r] = a & b;
            4'd1: nv[r] = a & ~b;
            4'd2: nv[r] = a | b;
            4'd3: nv[r] = a | ~b;
            4'd4: nv[r] = a ^ b;
            4'd8: begin
                sz = r[1] ? 8 : 4;
                if ((int'(s) % sz) == 0) begin
                    any_v = 1'b0;
                    all_v = 1'b1;
                    for (int k = 0; k < sz; k++) begin
                        any_v |= cur[int'(s) + k];
                        all_v &= cur[int'(s) + k];
                    end
                    nv[t] = r[0] ? all_v : any_v;
                end
            end
            default: nv = cur;
        endcase
        return nv;
    endfunction

    // One operation: drive at falling edge, check outputs, check flags after the edge
    task automatic step(input string req, input logic v, input logic [3:0] op,
                        input logic [3:0] r, input logic [3:0] s, input logic [3:0] t,
                        input logic sre, input logic [31:0] srd,
                        input logic [7:0] off, input logic [31:0] pcv);
        logic exp_mv, exp_tk, exp_il;
        logic [15:0] nxt;
        int sz;
        @(negedge clk);
        op_valid = v; op_code = op; fld_r = r; fld_s = s; fld_t = t;
        sr_wr_en = sre; sr_wr_data = srd; br_offset = off; pc = pcv;
        #1;
        sz = r[1] ? 8 : 4;
        exp_mv = v && ((op == 4'd12 && !model[t]) || (op == 4'd13 && model[t]));
        exp_il = v && ((op == 4'd8 && (int'(s) % sz) != 0) || (op == 4'd14 && r > 4'd1));
        exp_tk = v && op == 4'd14 && r <= 4'd1 && (r[0] ? model[s] : !model[s]);
        chk({req, " move_en"}, {31'b0, move_en}, {31'b0, exp_mv});
        chk({req, " branch_taken"}, {31'b0, branch_taken}, {31'b0, exp_tk});
        chk({req, " illegal"}, {31'b0, illegal}, {31'b0, exp_il});
        if (op == 4'd14)
            chk("R8 target", branch_target, pcv + 32'd4 + {{24{off[7]}}, off});
        nxt = next_model(model, v, op, r, s, t, sre, srd);
        @(negedge clk);
        op_valid = 1'b0; sr_wr_en = 1'b0;
        #1;
        chk({req, " flags"}, cond_q, {16'h0, nxt});
        model = nxt;
    endtask

    task automatic load(input logic [15:0] val);
        step("R2", 1'b0, 4'd15, 4'd0, 4'd0, 4'd0, 1'b1, {16'hFFFF, val}, 8'd0, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset", cond_q, 32'h0);
        load(16'h5A5A);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        model = 16'h0;
        chk("R1 reset mid-run", cond_q, 32'h0);
    endtask

    task automatic t_sr_write;
        step("R2", 1'b0, 4'd15, 4'd0, 4'd0, 4'd0, 1'b1, 32'hABCD1234, 8'd0, 32'd0);
        chk("R1 upper zero", {16'h0, cond_q[31:16]}, 32'h0);
    endtask

    task automatic t_logic;
        load(16'h00F0);
        step("R3 and",  1'b1, 4'd0, 4'd0, 4'd4, 4'd5, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R3 andc", 1'b1, 4'd1, 4'd1, 4'd4, 4'd5, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R3 orc",  1'b1, 4'd3, 4'd2, 4'd8, 4'd9, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R3 xor",  1'b1, 4'd4, 4'd4, 4'd4, 4'd0, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R3 or",   1'b1, 4'd2, 4'd15, 4'd9, 4'd6, 1'b0, 32'd0, 8'd0, 32'd0);
        chk("R3 result word", cond_q, 32'h0000_80E5);
    endtask

    task automatic t_reduce;
        load(16'h0F70);
        step("R4 any4 s0",  1'b1, 4'd8, 4'd0, 4'd0,  4'd15, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R4 all4 s8",  1'b1, 4'd8, 4'd1, 4'd8,  4'd14, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R4 all8 s8",  1'b1, 4'd8, 4'd3, 4'd8,  4'd13, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R4 any8 s0",  1'b1, 4'd8, 4'd2, 4'd0,  4'd12, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R4 all4 s4",  1'b1, 4'd8, 4'd1, 4'd4,  4'd0,  1'b0, 32'd0, 8'd0, 32'd0);
        chk("R4 result word", cond_q, 32'h0000_5F70);
    endtask

    task automatic t_misaligned;
        load(16'hFFF0);
        step("R5 any4 s2", 1'b1, 4'd8, 4'd0, 4'd2, 4'd0, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R5 all8 s4", 1'b1, 4'd8, 4'd3, 4'd4, 4'd1, 1'b0, 32'd0, 8'd0, 32'd0);
        chk("R5 unchanged", cond_q, 32'h0000_FFF0);
    endtask

    task automatic t_move;
        load(16'h0002);
        step("R6 movf b0", 1'b1, 4'd12, 4'd3, 4'd4, 4'd0, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R6 movf b1", 1'b1, 4'd12, 4'd3, 4'd4, 4'd1, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R6 movt b1", 1'b1, 4'd13, 4'd3, 4'd4, 4'd1, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R6 movt b0", 1'b1, 4'd13, 4'd3, 4'd4, 4'd0, 1'b0, 32'd0, 8'd0, 32'd0);
    endtask

    task automatic t_branch;
        load(16'h0400);
        step("R7 bf clear", 1'b1, 4'd14, 4'd0, 4'd3,  4'd0, 1'b0, 32'd0, 8'h10, 32'h1000);
        step("R7 bf set",   1'b1, 4'd14, 4'd0, 4'd10, 4'd0, 1'b0, 32'd0, 8'h10, 32'h1000);
        step("R7 bt set",   1'b1, 4'd14, 4'd1, 4'd10, 4'd0, 1'b0, 32'd0, 8'hF0, 32'h2000);
        step("R7 bt clear", 1'b1, 4'd14, 4'd1, 4'd3,  4'd0, 1'b0, 32'd0, 8'h80, 32'h0000_0010);
        step("R7 bad r",    1'b1, 4'd14, 4'd2, 4'd10, 4'd0, 1'b0, 32'd0, 8'h7F, 32'h3000);
    endtask

    task automatic t_priority;
        load(16'h0001);
        // write clears b0 while movt tests b0: move_en sees the old value
        step("R10 movt", 1'b1, 4'd13, 4'd2, 4'd3, 4'd0, 1'b1, 32'h0000_0080, 8'd0, 32'd0);
        // logic op to b5 dropped in favour of the special-register write
        step("R2 priority", 1'b1, 4'd2, 4'd5, 4'd7, 4'd7, 1'b1, 32'h0000_1100, 8'd0, 32'd0);
        chk("R2 priority word", cond_q, 32'h0000_1100);
    endtask

    task automatic t_idle;
        load(16'h0003);
        step("R9 idle logic",  1'b0, 4'd2, 4'd9, 4'd0, 4'd1, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R9 idle move",   1'b0, 4'd13, 4'd9, 4'd0, 4'd1, 1'b0, 32'd0, 8'd0, 32'd0);
        step("R9 idle branch", 1'b0, 4'd14, 4'd1, 4'd0, 4'd1, 1'b0, 32'd0, 8'd0, 32'd0);
        chk("R9 unchanged", cond_q, 32'h0000_0003);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model = 16'h0;
        rst = 1'b1; op_valid = 1'b0; op_code = 4'd15;
        fld_r = 4'd0; fld_s = 4'd0; fld_t = 4'd0;
        sr_wr_en = 1'b0; sr_wr_data = 32'd0; br_offset = 8'd0; pc = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_sr_write();
        t_logic();
        t_reduce();
        t_misaligned();
        t_move();
        t_branch();
        t_priority();
        t_idle();
        finish_run();
    end
endmodule